// File: doc/BRIEF.md
# AHB Burst Address Generator

This block drives the address side of an AHB master during a burst. The user asserts a start request while the generator is idle and gives it a start address, a 3-bit burst code, a transfer size and a write flag. From the next cycle it presents one address per beat. The address moves to the next beat only in a cycle where the slave's ready is high.

Fixed-length bursts end by themselves after their beat count. An incrementing burst of unspecified length runs until the user raises a stop input on the beat that is to be the last one. Each beat is tagged as the opening (non-sequential) beat or as a following (sequential) beat. The final beat of every burst whose length is known up front is flagged.

The address arithmetic touches only the low ten bits, so a burst can never leave its 1 KB region. Wrapping bursts mask the step to a block whose size is the beat count times the transfer size. Size, burst code and direction are captured at the start and held for the whole burst.

Top module: `ahb_burst_agen`

## Requirements
- R1: While reset is high, and in the cycle after it, `valid_o` is low.
- R2: A start request sampled while idle makes `valid_o` high in the next cycle, with `addr_o` equal to the start address and `first_o` high.
- R3: While `valid_o` is high and `ready_i` is low, `addr_o`, `first_o` and `last_o` hold and the burst stays active.
- R4: In incrementing bursts (codes 001, 011, 101, 111) each beat's address is the previous one plus 2^size bytes, where size is 0 for byte, 1 for halfword and 2 for word.
- R5: In wrapping bursts (codes 010, 100, 110) the low address bits inside a block of beats×2^size bytes step by 2^size and roll back to the block start; the address bits above the block stay fixed. A word 4-beat wrap from 0x1008 gives 0x1008, 0x100C, 0x1000, 0x1004.
- R6: Code 000 yields one beat. Codes 010/011 yield 4 beats, 100/101 yield 8 beats and 110/111 yield 16 beats. After the final beat is accepted, `valid_o` goes low.
- R7: `last_o` is high exactly on the final beat of a burst of codes 000 and 010–111, and never during code 001.
- R8: A code 001 burst ends after the beat on which `stop_i` and `ready_i` are both high. `stop_i` with `ready_i` low has no effect.
- R9: Address bits 10 and up keep their start value for the whole burst. The low ten bits count modulo 1024.
- R10: `size_o`, `burst_o` and `write_o` equal the values captured at start for every beat of the burst.
- R11: `first_o` is high only on the opening beat. All later beats show it low.
- R12: A start request while a burst is active is ignored and does not change the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a burst (taken only when idle) |
| start_addr_i | input | AW | First beat address, aligned to size |
| burst_i | input | 3 | Burst code |
| size_i | input | 2 | Transfer size code |
| write_i | input | 1 | Direction of the burst |
| ready_i | input | 1 | Slave ready; beat advances when high |
| stop_i | input | 1 | Ends an unspecified-length burst on this beat |
| valid_o | output | 1 | A beat address is being presented |
| addr_o | output | AW | Current beat address |
| first_o | output | 1 | Opening, non-sequential beat |
| last_o | output | 1 | Final beat of a known-length burst |
| size_o | output | 2 | Held transfer size |
| burst_o | output | 3 | Held burst code |
| write_o | output | 1 | Held direction |

## Verification
Several properties are checked on every cycle:
- stall hold of the beat outputs;
- loading of the start address;
- `first_o` dropping after the first accepted beat;
- constancy of the captured controls;
- the frozen upper address bits;
- the exact step of incrementing bursts;
- the absence of a last flag in open-ended bursts.

Other behaviour needs whole bursts driven from the bench:
- wrap roll-back positions for each length and size;
- exact beat counts;
- termination of open-ended bursts by the stop input;
- rejection of start requests that arrive mid-burst.

// File: rtl/bag_pkg.sv
package bag_pkg;

    localparam int BEAT_W = 5;

    typedef enum logic [1:0] {
        BK_SINGLE     = 2'd0,
        BK_INCR_OPEN  = 2'd1,
        BK_INCR_FIXED = 2'd2,
        BK_WRAP       = 2'd3
    } burst_kind_e;

    typedef struct packed {
        burst_kind_e        kind;
        logic [BEAT_W-1:0]  beats;
    } burst_info_t;

    // beat count chosen by the two upper code bits of a fixed burst
    function automatic logic [BEAT_W-1:0] fixed_beats(input logic [1:0] len_sel);
        logic [BEAT_W-1:0] n;
        case (len_sel)
            2'd1:    n = BEAT_W'(4);
            2'd2:    n = BEAT_W'(8);
            2'd3:    n = BEAT_W'(16);
            default: n = BEAT_W'(1);
        endcase
        return n;
    endfunction

endpackage

// File: rtl/bag_decode.sv
module bag_decode
    import bag_pkg::*;
(
    input  logic [2:0]   code_i,
    output burst_info_t  info_o
);
    always_comb begin
        info_o.kind  = BK_SINGLE;
        info_o.beats = BEAT_W'(1);
        if (code_i == 3'b000) begin
            info_o.kind  = BK_SINGLE;
            info_o.beats = BEAT_W'(1);
        end else if (code_i == 3'b001) begin
            info_o.kind  = BK_INCR_OPEN;
            info_o.beats = '0;
        end else begin
            info_o.kind  = code_i[0] ? BK_INCR_FIXED : BK_WRAP;
            info_o.beats = fixed_beats(code_i[2:1]);
        end
    end
endmodule

// File: rtl/bag_addr_next.sv
module bag_addr_next
    import bag_pkg::*;
#(
    parameter int BW = 10
) (
    input  logic [BW-1:0] low_i,
    input  logic [1:0]    size_i,
    input  burst_info_t   info_i,
    output logic [BW-1:0] low_o
);
    logic [BW-1:0] step;
    logic [BW-1:0] blk_mask;
    logic [BW-1:0] sum;

    always_comb begin
        step     = BW'(1) << size_i;
        blk_mask = (BW'(info_i.beats) << size_i) - BW'(1);
        sum      = low_i + step;
        if (info_i.kind == BK_WRAP)
            low_o = (low_i & ~blk_mask) | (sum & blk_mask);
        else
            low_o = sum;
    end
endmodule

// File: rtl/bag_beat_ctrl.sv
module bag_beat_ctrl
    import bag_pkg::*;
#(
    parameter int AW = 32,
    parameter int BW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic [AW-1:0] start_addr_i,
    input  logic [2:0]    code_i,
    input  burst_info_t   info_i,
    input  logic [1:0]    size_i,
    input  logic          write_i,
    input  logic          ready_i,
    input  logic          stop_i,
    input  logic [BW-1:0] next_low_i,
    output logic          valid_o,
    output logic [AW-1:0] addr_o,
    output logic          first_o,
    output logic          last_o,
    output burst_info_t   info_o,
    output logic [1:0]    size_o,
    output logic [2:0]    code_o,
    output logic          write_o
);
    logic              active_q;
    logic [AW-1:0]     addr_q;
    logic [BEAT_W-1:0] cnt_q;
    logic              first_q;
    burst_info_t       info_q;
    logic [1:0]        size_q;
    logic [2:0]        code_q;
    logic              write_q;
    logic              advance;
    logic              finish;
    logic              fixed_last;

    assign fixed_last = active_q && (info_q.kind != BK_INCR_OPEN)
                        && (cnt_q == info_q.beats - BEAT_W'(1));
    assign advance    = active_q && ready_i;
    assign finish     = advance && (fixed_last || (info_q.kind == BK_INCR_OPEN && stop_i));

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            first_q  <= 1'b0;
            cnt_q    <= '0;
            addr_q   <= '0;
            info_q   <= '{kind: BK_SINGLE, beats: BEAT_W'(1)};
            size_q   <= '0;
            code_q   <= '0;
            write_q  <= 1'b0;
        end else if (!active_q && start_i) begin
            active_q <= 1'b1;
            first_q  <= 1'b1;
            cnt_q    <= '0;
            addr_q   <= start_addr_i;
            info_q   <= info_i;
            size_q   <= size_i;
            code_q   <= code_i;
            write_q  <= write_i;
        end else if (advance) begin
            first_q <= 1'b0;
            if (finish) begin
                active_q <= 1'b0;
            end else begin
                addr_q <= {addr_q[AW-1:BW], next_low_i};
                cnt_q  <= cnt_q + BEAT_W'(1);
            end
        end
    end

    assign valid_o = active_q;
    assign addr_o  = addr_q;
    assign first_o = first_q;
    assign last_o  = fixed_last;
    assign info_o  = info_q;
    assign size_o  = size_q;
    assign code_o  = code_q;
    assign write_o = write_q;

    a_r1_reset_idle: assert property (@(posedge clk) rst |=> !valid_o);

    a_r2_start_load: assert property (@(posedge clk) disable iff (rst)
        (!valid_o && start_i) |=> (valid_o && first_o && addr_o == $past(start_addr_i)));

    a_r3_stall_hold: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !ready_i) |=> (valid_o && $stable(addr_o) && $stable(first_o) && $stable(last_o)));

    a_r11_first_drops: assert property (@(posedge clk) disable iff (rst)
        (valid_o && ready_i && !finish) |=> (valid_o && !first_o));

    a_r10_ctrl_held: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !finish) |=> ($stable(size_o) && $stable(code_o) && $stable(write_o)));
endmodule

// File: rtl/ahb_burst_agen.sv
module ahb_burst_agen
    import bag_pkg::*;
#(
    parameter int AW = 32,
    parameter int BW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic [AW-1:0] start_addr_i,
    input  logic [2:0]    burst_i,
    input  logic [1:0]    size_i,
    input  logic          write_i,
    input  logic          ready_i,
    input  logic          stop_i,
    output logic          valid_o,
    output logic [AW-1:0] addr_o,
    output logic          first_o,
    output logic          last_o,
    output logic [1:0]    size_o,
    output logic [2:0]    burst_o,
    output logic          write_o
);
    burst_info_t   start_info;
    burst_info_t   cur_info;
    logic [BW-1:0] next_low;

    bag_decode u_decode (
        .code_i (burst_i),
        .info_o (start_info)
    );

    bag_addr_next #(.BW(BW)) u_next (
        .low_i  (addr_o[BW-1:0]),
        .size_i (size_o),
        .info_i (cur_info),
        .low_o  (next_low)
    );

    bag_beat_ctrl #(.AW(AW), .BW(BW)) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .start_addr_i (start_addr_i),
        .code_i       (burst_i),
        .info_i       (start_info),
        .size_i       (size_i),
        .write_i      (write_i),
        .ready_i      (ready_i),
        .stop_i       (stop_i),
        .next_low_i   (next_low),
        .valid_o      (valid_o),
        .addr_o       (addr_o),
        .first_o      (first_o),
        .last_o       (last_o),
        .info_o       (cur_info),
        .size_o       (size_o),
        .code_o       (burst_o),
        .write_o      (write_o)
    );

    a_r9_upper_frozen: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !first_o) |-> (addr_o[AW-1:BW] == $past(addr_o[AW-1:BW])));

    a_r7_open_no_last: assert property (@(posedge clk) disable iff (rst)
        (valid_o && burst_o == 3'b001) |-> !last_o);

    a_r4_incr_step: assert property (@(posedge clk) disable iff (rst)
        ($past(valid_o && ready_i) && valid_o && !first_o && burst_o[0])
        |-> (addr_o[BW-1:0] == BW'($past(addr_o[BW-1:0]) + (BW'(1) << size_o))));
endmodule

// File: tb/ahb_burst_agen_tb.sv
module ahb_burst_agen_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst;
    logic        start_i;
    logic [31:0] start_addr_i;
    logic [2:0]  burst_i;
    logic [1:0]  size_i;
    logic        write_i;
    logic        ready_i;
    logic        stop_i;
    logic        valid_o;
    logic [31:0] addr_o;
    logic        first_o;
    logic        last_o;
    logic [1:0]  size_o;
    logic [2:0]  burst_o;
    logic        write_o;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ahb_burst_agen dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .start_addr_i(start_addr_i),
        .burst_i(burst_i), .size_i(size_i), .write_i(write_i), .ready_i(ready_i),
        .stop_i(stop_i), .valid_o(valid_o), .addr_o(addr_o), .first_o(first_o),
        .last_o(last_o), .size_o(size_o), .burst_o(burst_o), .write_o(write_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic int beats_of(input logic [2:0] code);
        case (code)
            3'b000:         return 1;
            3'b010, 3'b011: return 4;
            3'b100, 3'b101: return 8;
            default:        return 16;
        endcase
    endfunction

    function automatic logic [31:0] exp_next(input logic [31:0] a, input logic [2:0] code,
                                             input logic [1:0] sz);
        logic [9:0] lo;
        logic [9:0] st;
        logic [9:0] m;
        lo = a[9:0];
        st = 10'(1) << sz;
        if (code != 3'b000 && code != 3'b001 && code[0] == 1'b0) begin
            m  = 10'((beats_of(code) << sz) - 1);
            lo = (lo & ~m) | ((lo + st) & m);
        end else begin
            lo = lo + st;
        end
        return {a[31:10], lo};
    endfunction

    // Runs one burst end to end, checking every presented beat.
    task automatic run_burst(input logic [31:0] a, input logic [2:0] code, input logic [1:0] sz,
                             input bit wr, input int open_len, input int stall_pct, input bit poke);
        int n;
        int b;
        bit rdy;
        logic [31:0] exp;
        @(negedge clk);
        start_i = 1'b1; start_addr_i = a; burst_i = code; size_i = sz; write_i = wr;
        ready_i = 1'b0; stop_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        n   = (code == 3'b001) ? open_len : beats_of(code);
        exp = a;
        b   = 0;
        while (b < n) begin
            chk(valid_o == 1'b1, (b == 0) ? "R2" : "R3", "valid during burst", 32'(valid_o), 1);
            chk(addr_o == exp, (code[0] || code == 3'b000) ? "R4" : "R5", "beat address", addr_o, exp);
            chk(addr_o[31:10] == a[31:10], "R9", "upper address bits", addr_o, a);
            chk(first_o == (b == 0), "R11", "first flag", 32'(first_o), 32'(b == 0));
            chk(last_o == (code != 3'b001 && b == n - 1), "R7", "last flag",
                32'(last_o), 32'(code != 3'b001 && b == n - 1));
            chk(size_o == sz && burst_o == code && write_o == wr, "R10", "held controls",
                {27'd0, write_o, burst_o, size_o}, {27'd0, wr, code, sz});
            rdy = (int'($urandom_range(99)) >= stall_pct);
            ready_i = rdy;
            stop_i  = (code == 3'b001 && b == n - 1);  // R8: stop with ready low must not end
            if (poke && b > 0) begin
                start_i = 1'b1; start_addr_i = ~a; burst_i = ~code; size_i = 2'd0; write_i = ~wr;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
            if (rdy) begin
                b++;
                exp = exp_next(exp, code, sz);
            end
        end
        ready_i = 1'b0; stop_i = 1'b0; start_i = 1'b0;
        chk(valid_o == 1'b0, (code == 3'b001) ? "R8" : "R6", "idle after final beat", 32'(valid_o), 0);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1; start_i = 1'b0; start_addr_i = '0; burst_i = '0; size_i = '0;
        write_i = 1'b0; ready_i = 1'b0; stop_i = 1'b0;
        repeat (3) @(negedge clk);
        chk(valid_o == 1'b0, "R1", "idle in reset", 32'(valid_o), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(valid_o == 1'b0, "R1", "idle after reset", 32'(valid_o), 0);

        // R5 directed: word wrap4 from 0x1008 -> 1008,100C,1000,1004
        run_burst(32'h0000_1008, 3'b010, 2'd2, 1'b0, 0, 0, 1'b0);
        // R9 directed: incr16 word near the 1 KB edge, low bits roll over
        run_burst(32'hABCD_FFF0, 3'b111, 2'd2, 1'b1, 0, 0, 1'b0);
        // R6 single, R8 open burst with stalls, R12 starts during busy
        run_burst(32'h0000_0040, 3'b000, 2'd1, 1'b1, 0, 50, 1'b0);
        run_burst(32'h0000_03FE, 3'b001, 2'd1, 1'b0, 5, 40, 1'b1);
        run_burst(32'h1234_5673, 3'b110, 2'd0, 1'b0, 0, 30, 1'b1);
        run_burst(32'h0000_07C4, 3'b100, 2'd2, 1'b1, 0, 30, 1'b0);

        for (int i = 0; i < 80; i++) begin
            logic [2:0]  code;
            logic [1:0]  sz;
            logic [31:0] a;
            code = 3'($urandom_range(7));
            sz   = 2'($urandom_range(2));
            a    = $urandom & ~((32'd1 << sz) - 32'd1);
            run_burst(a, code, sz, 1'($urandom_range(1)), 1 + int'($urandom_range(19)),
                      int'($urandom_range(60)), 1'($urandom_range(1)));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule